// File: doc/BRIEF.md
# Power Converter Fault Supervisor

This block is the protection sequencer of a multi-rail power supply controller. It receives already-digitized comparator results: output over-voltage, switching-stage over-current, and under-voltage on each linear output. It also receives a power-on reset request and shutdown requests for rail 1 and rail 3. From these it drives one inhibit line to every converter, a soft-start ramp with discharge control, a retry count and a sticky fault flag.

An over-current trip blocks all outputs. The soft-start ramp still climbs to its top code, then falls back to zero, and the supply tries again. This hiccup retry repeats until the third trip, which latches a permanent fault. An over-voltage latches the fault at once. Under-voltage on a linear rail counts as an over-current, but only once the ramp is fully charged, so the rails can rise during start-up without a trip. The soft-start ramp is a digital up/down counter whose height is set by a parameter.

Top module: `pwr_fault_supervisor`

## Requirements
- R1: Every comparator and control input passes through a two-stage synchronizer. An input change first affects a registered output on the third rising clock edge after it is applied.
- R2: A synchronized over-voltage sets `fault` on the next edge. This does not wait for any retry and does not change `retry_cnt`.
- R3: A synchronized over-current while `drive_en` is high sets the over-current latch, which raises `inhibit`. Each rising edge of that latch adds exactly one to `retry_cnt`.
- R4: An over-current while `drive_en` is low is ignored: `inhibit` and `retry_cnt` stay unchanged.
- R5: Outside clear, the ramp `ss_level` climbs by one per clock from 0 while `ss_discharge` is low and stops at SS_TOP. `ss_full` is high exactly when `ss_level` equals SS_TOP.
- R6: With the over-current latch set, the ramp keeps climbing to SS_TOP. It then raises `ss_discharge` and falls by one per clock. At code 0 the latch clears, `ss_discharge` drops, and `inhibit` falls unless `fault` is set.
- R7: Under-voltage on any linear rail sets the over-current latch only while `ss_full` is high. While the ramp is below SS_TOP it has no effect.
- R8: The third over-current latch event sets `fault`. `retry_cnt` then saturates at 3, and `fault` stays high with `inhibit` high.
- R9: A power-on reset request clears `retry_cnt`, `fault`, the over-current latch and the ramp. So do rail-1 and rail-3 shutdown requests that are both high. A single shutdown request clears nothing.
- R10: After the synchronous active-low reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ov_in | input | 1 | Output over-voltage comparator result |
| oc_in | input | 1 | Switching-stage over-current comparator result |
| drive_en | input | 1 | Switching drive active; qualifies `oc_in` |
| uv_in | input | LIN_N | Under-voltage result, one bit per linear rail |
| por_in | input | 1 | Power-on reset request; clears counter and latches |
| shdn1_in | input | 1 | Rail 1 shutdown request |
| shdn3_in | input | 1 | Rail 3 shutdown request |
| inhibit | output | 1 | Disables all converters |
| ss_discharge | output | 1 | Ramp is discharging |
| ss_full | output | 1 | Ramp is at its top code |
| ss_level | output | SS_W | Soft-start ramp code |
| retry_cnt | output | 2 | Over-current events since last clear, saturating at 3 |
| fault | output | 1 | Latched permanent fault |

## Verification
The bench builds the block with SS_W = 3 and SS_TOP = 6 instead of 8 and 200. With these values a full hiccup cycle takes about a dozen clocks, so three retries, saturation of the count and both clear paths all fit in a short run. The small ramp also makes under-voltage blanking testable: a pulse inside the climb and a pulse at the top are only a few clocks apart. A behavioural model of the ramp, latch and counter is stepped on every clock and compared against all outputs.

// File: rtl/pfs_pkg.sv
// Package pfs_pkg
// Shared constants and the synchronized-input record for the fault supervisor.
// Assumes the retry limit is fixed by the protection scheme at three events.
package pfs_pkg;
    localparam int RETRY_MAX   = 3;
    localparam int CNT_W       = $clog2(RETRY_MAX + 1);
    localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/pfs_sync.sv
// Module pfs_sync
// Multi-bit chain of flip-flops that brings asynchronous comparator results
// into the clock domain. Each bit is independent; no coherency between bits
// is assumed or provided.
module pfs_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // capture raw input into the first stage
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                // shift through the remaining stages
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[i] <= '0;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pfs_softstart.sv
// Module pfs_softstart
// Digital soft-start ramp. Climbs by one per clock to TOP and rests there.
// If hold (over-current latch) is set at TOP, it turns and discharges to 0.
// At 0 it pulses release for one cycle and starts climbing again.
// Assumes hold cannot clear on its own while discharging.
module pfs_softstart #(
    parameter int SS_W   = 8,
    parameter int SS_TOP = 200
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            hold,
    output logic [SS_W-1:0] level,
    output logic            full,
    output logic            discharging,
    output logic            release_o
);
    localparam logic [SS_W-1:0] TOP_CODE = SS_W'(SS_TOP);
    localparam logic [SS_W-1:0] ONE      = SS_W'(1);

    logic [SS_W-1:0] lvl_q;
    logic            dis_q;

    // ramp counter with direction flag
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            lvl_q <= '0;
            dis_q <= 1'b0;
        end else if (!dis_q) begin
            if (lvl_q != TOP_CODE)  lvl_q <= lvl_q + ONE;
            else if (hold)          dis_q <= 1'b1;
        end else begin
            if (lvl_q != '0)        lvl_q <= lvl_q - ONE;
            else                    dis_q <= 1'b0;
        end
    end

    // decode ramp state for the rest of the block
    always_comb begin
        level       = lvl_q;
        full        = (lvl_q == TOP_CODE);
        discharging = dis_q;
        release_o   = dis_q && (lvl_q == '0);
    end
endmodule

// File: rtl/pfs_retry.sv
// Module pfs_retry
// Over-current latch, retry counter and permanent fault latch.
// The counter advances once per rising edge of the over-current latch and
// saturates at RETRY_MAX; the event that brings it to RETRY_MAX sets the fault.
// Over-voltage sets the fault directly. Clear has priority over all sets.
module pfs_retry
    import pfs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             oc_trip,
    input  logic             uv_trip,
    input  logic             ov_trip,
    input  logic             release_i,
    output logic             ocl,
    output logic [CNT_W-1:0] cnt,
    output logic             fault
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RETRY_MAX);
    localparam logic [CNT_W-1:0] CNT_PRE  = CNT_W'(RETRY_MAX - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic ocl_nxt;
    logic ocl_rise;

    // next latch state: release beats a coincident set
    always_comb begin
        ocl_nxt  = release_i ? 1'b0 : (ocl | oc_trip | uv_trip);
        ocl_rise = ocl_nxt && !ocl;
    end

    // over-current latch
    always_ff @(posedge clk) begin
        if (!rst_n || clr) ocl <= 1'b0;
        else               ocl <= ocl_nxt;
    end

    // saturating retry counter
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                    cnt <= '0;
        else if (ocl_rise && cnt != CNT_LAST) cnt <= cnt + CNT_ONE;
    end

    // permanent fault latch
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                        fault <= 1'b0;
        else if (ov_trip || (ocl_rise && cnt == CNT_PRE)) fault <= 1'b1;
    end
endmodule

// File: rtl/pwr_fault_supervisor.sv
// Module pwr_fault_supervisor
// Top of the fault supervisor: synchronizes inputs, qualifies trips,
// runs the soft-start ramp and the retry/fault latches, and forms inhibit.
// Assumes comparator inputs are asynchronous single bits.
module pwr_fault_supervisor
    import pfs_pkg::*;
#(
    parameter int SS_W   = 8,
    parameter int SS_TOP = 200,
    parameter int LIN_N  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ov_in,
    input  logic             oc_in,
    input  logic             drive_en,
    input  logic [LIN_N-1:0] uv_in,
    input  logic             por_in,
    input  logic             shdn1_in,
    input  logic             shdn3_in,
    output logic             inhibit,
    output logic             ss_discharge,
    output logic             ss_full,
    output logic [SS_W-1:0]  ss_level,
    output logic [CNT_W-1:0] retry_cnt,
    output logic             fault
);
    localparam int IN_W = 6 + LIN_N;

    logic [IN_W-1:0]  raw_v;
    logic [IN_W-1:0]  syn_v;
    logic [LIN_N-1:0] s_uv;
    logic             s_ov, s_oc, s_drv, s_por, s_sd1, s_sd3;
    logic             clr, oc_trip, uv_any, ov_trip;
    logic             ocl, ss_release;

    // pack raw inputs for the synchronizer
    assign raw_v = {por_in, shdn1_in, shdn3_in, drive_en, oc_in, ov_in, uv_in};

    pfs_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_v),
        .q     (syn_v)
    );

    // unpack synchronized inputs and qualify trips
    always_comb begin
        {s_por, s_sd1, s_sd3, s_drv, s_oc, s_ov, s_uv} = syn_v;
        clr     = s_por || (s_sd1 && s_sd3);
        oc_trip = s_oc && s_drv;
        uv_any  = |s_uv;
        ov_trip = s_ov;
    end

    pfs_softstart #(.SS_W(SS_W), .SS_TOP(SS_TOP)) u_ss (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr),
        .hold        (ocl),
        .level       (ss_level),
        .full        (ss_full),
        .discharging (ss_discharge),
        .release_o   (ss_release)
    );

    pfs_retry u_retry (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .oc_trip   (oc_trip),
        .uv_trip   (uv_any && ss_full),
        .ov_trip   (ov_trip),
        .release_i (ss_release),
        .ocl       (ocl),
        .cnt       (retry_cnt),
        .fault     (fault)
    );

    // converters stay off while either latch is set
    assign inhibit = ocl || fault;
endmodule

// File: rtl/pfs_checker.sv
// Module pfs_checker
// Temporal properties of the fault supervisor, bound into the top module.
module pfs_checker
    import pfs_pkg::*;
#(
    parameter int SS_W   = 8,
    parameter int SS_TOP = 200
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             ov_trip,
    input logic             oc_trip,
    input logic             uv_any,
    input logic             ocl,
    input logic             inhibit,
    input logic             ss_full,
    input logic             ss_discharge,
    input logic [SS_W-1:0]  ss_level,
    input logic [CNT_W-1:0] retry_cnt,
    input logic             fault
);
    localparam logic [SS_W-1:0]  TOP_CODE = SS_W'(SS_TOP);
    localparam logic [SS_W-1:0]  ONE      = SS_W'(1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RETRY_MAX);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    a_r2_ov_sets_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_trip && !clr) |=> fault);

    a_r3_count_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ocl) && $past(retry_cnt) != CNT_LAST) |-> retry_cnt == $past(retry_cnt) + CNT_ONE);

    a_r5_ramp_climbs: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (!clr && !ss_discharge && ss_level != TOP_CODE) |=> ss_level == $past(ss_level) + ONE);

    a_r6_discharge_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_discharge) |-> $past(ocl));

    a_r7_uv_blanked: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_any && !ss_full && !ocl && !oc_trip && !clr) |=> !ocl);

    a_r8_count_saturates: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (retry_cnt == CNT_LAST && !clr) |=> retry_cnt == CNT_LAST);

    a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (retry_cnt == '0 && !fault && !inhibit));
endmodule

bind pwr_fault_supervisor pfs_checker #(.SS_W(SS_W), .SS_TOP(SS_TOP)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (clr),
    .ov_trip      (ov_trip),
    .oc_trip      (oc_trip),
    .uv_any       (uv_any),
    .ocl          (ocl),
    .inhibit      (inhibit),
    .ss_full      (ss_full),
    .ss_discharge (ss_discharge),
    .ss_level     (ss_level),
    .retry_cnt    (retry_cnt),
    .fault        (fault)
);

// File: tb/pwr_fault_supervisor_test.sv
module pwr_fault_supervisor_test;
    localparam int SS_W  = 3;
    localparam int TOP   = 6;
    localparam int LIN_N = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ov_in = 0, oc_in = 0, drive_en = 0, por_in = 0, shdn1_in = 0, shdn3_in = 0;
    logic [LIN_N-1:0] uv_in = '0;
    logic inhibit, ss_discharge, ss_full, fault;
    logic [SS_W-1:0] ss_level;
    logic [1:0] retry_cnt;

    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pwr_fault_supervisor #(.SS_W(SS_W), .SS_TOP(TOP), .LIN_N(LIN_N)) uut (
        .clk(clk), .rst_n(rst_n), .ov_in(ov_in), .oc_in(oc_in), .drive_en(drive_en),
        .uv_in(uv_in), .por_in(por_in), .shdn1_in(shdn1_in), .shdn3_in(shdn3_in),
        .inhibit(inhibit), .ss_discharge(ss_discharge), .ss_full(ss_full),
        .ss_level(ss_level), .retry_cnt(retry_cnt), .fault(fault)
    );

    // behavioural reference: inputs seen two edges late, then ramp/latch/count
    int m_ss, m_dis, m_ocl, m_cnt, m_fault;
    logic [7:0] h1, h2;  // {por, sd1, sd3, drv, oc, ov, uv[1:0]}

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ss = 0; m_dis = 0; m_ocl = 0; m_cnt = 0; m_fault = 0;
            h1 = '0; h2 = '0;
        end else begin
            bit c_clr, rel, full, oct, uvt, rise;
            int n_ocl;
            c_clr = h2[7] || (h2[6] && h2[5]);
            rel   = (m_dis == 1) && (m_ss == 0);
            full  = (m_ss == TOP);
            oct   = h2[4] && h2[3];
            uvt   = (h2[1:0] != 0) && full;
            if (c_clr) begin
                m_ss = 0; m_dis = 0; m_ocl = 0; m_cnt = 0; m_fault = 0;
            end else begin
                n_ocl = rel ? 0 : ((m_ocl != 0 || oct || uvt) ? 1 : 0);
                rise  = (n_ocl == 1) && (m_ocl == 0);
                if (h2[2] || (rise && m_cnt == 2)) m_fault = 1;
                if (rise && m_cnt < 3) m_cnt++;
                if (m_dis == 0) begin
                    if (m_ss != TOP) m_ss++;
                    else if (m_ocl == 1) m_dis = 1;
                end else begin
                    if (m_ss != 0) m_ss--;
                    else m_dis = 0;
                end
                m_ocl = n_ocl;
            end
            h2 = h1;
            h1 = {por_in, shdn1_in, shdn3_in, drive_en, oc_in, ov_in, uv_in};
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            chk("R5 ss_level",    int'(ss_level),     m_ss);
            chk("R5 ss_full",     int'(ss_full),      (m_ss == TOP) ? 1 : 0);
            chk("R6 ss_discharge",int'(ss_discharge), m_dis);
            chk("R3 inhibit",     int'(inhibit),      (m_ocl != 0 || m_fault != 0) ? 1 : 0);
            chk("R3 retry_cnt",   int'(retry_cnt),    m_cnt);
            chk("R8 fault",       int'(fault),        m_fault);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        cyc(2);
        // R10: outputs after reset
        chk("R10 inhibit", inhibit, 0);
        chk("R10 fault", fault, 0);
        chk("R10 retry_cnt", retry_cnt, 0);
        chk("R10 ss_level", ss_level, 0);
        rst_n = 1'b1;
        // R7: under-voltage during ramp climb is blanked
        uv_in = 2'b01; cyc(3); uv_in = '0;
        cyc(4);
        chk("R7 blanked inhibit", inhibit, 0);
        cyc(4);
        chk("R5 full at top", ss_full, 1);
        // R4: over-current without drive enable
        oc_in = 1; cyc(5); oc_in = 0; cyc(3);
        chk("R4 inhibit", inhibit, 0);
        chk("R4 retry_cnt", retry_cnt, 0);
        // R3 / R6: one qualified over-current, full hiccup
        drive_en = 1; oc_in = 1; cyc(1); oc_in = 0;
        cyc(4);
        chk("R3 inhibit raised", inhibit, 1);
        chk("R3 single count", retry_cnt, 1);
        cyc(20);
        chk("R6 inhibit released", inhibit, 0);
        chk("R6 discharge done", ss_discharge, 0);
        // R8: persistent over-current reaches the fault
        oc_in = 1; cyc(60);
        chk("R8 fault latched", fault, 1);
        chk("R8 count saturated", retry_cnt, 3);
        chk("R8 inhibit held", inhibit, 1);
        oc_in = 0; cyc(20);
        chk("R8 fault sticky", fault, 1);
        // R9: single shutdown does not clear, pair does
        shdn1_in = 1; cyc(6);
        chk("R9 single shutdown", fault, 1);
        shdn3_in = 1; cyc(5);
        chk("R9 pair clears fault", fault, 0);
        chk("R9 pair clears count", retry_cnt, 0);
        shdn1_in = 0; shdn3_in = 0; cyc(12);
        // R1 / R2: over-voltage latency and immediate fault
        ov_in = 1; cyc(2);
        chk("R1 not yet", fault, 0);
        cyc(1);
        chk("R1 third edge", fault, 1);
        ov_in = 0; cyc(2);
        chk("R2 count untouched", retry_cnt, 0);
        // R9: power-on reset clears
        por_in = 1; cyc(1); por_in = 0; cyc(5);
        chk("R9 por clears", fault, 0);
        cyc(10);
        // R7: under-voltage at full ramp trips
        chk("R7 ramp full", ss_full, 1);
        uv_in = 2'b10; cyc(1); uv_in = '0; cyc(4);
        chk("R7 uv trips", inhibit, 1);
        chk("R7 uv counts", retry_cnt, 1);
        cyc(30);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule